// File: doc/BRIEF.md
# Parallel ATA Device-Side DMA Word Mover

This block sits on the device side of a parallel ATA bus. It moves 16-bit words between a local word buffer and the host, using multiword-DMA style handshaking. The host's read strobe, write strobe and DMA acknowledge arrive as asynchronous levels. Each one goes through a two-flop synchronizer before its edges are detected in the single system clock domain. The shared data bus is resynchronized in the same way, so a captured word lines up with the strobe edge that qualifies it.

Local logic arms a transfer by pulsing `start` with a word count. While words remain and the local buffer can serve, the block raises its transfer request. It then waits for the host acknowledge. Each acknowledged strobe moves exactly one word. A falling read strobe puts the next source word on the bus. A rising write strobe hands the bus word to the sink. No direction input exists: the strobe that toggles picks the direction of each word. While a transfer is active, the 16-bit access indicator is held deasserted. When the count reaches zero, the request drops and the bus is released.

Top module: `pata_dma_dev`

## Requirements
- R1: After reset `xfer_req` is 0, `host_oe` is 0 and no words remain, so `wide_n` equals the inverse of `pio_wide`.
- R2: `xfer_req` rises only while words remain, the local side is ready (`src_valid` or `snk_ready` is 1) and the synchronized acknowledge is high.
- R3: Once raised, `xfer_req` stays 1 until the acknowledge is seen low. It then falls if no words remain or the local side is no longer ready.
- R4: A falling read strobe while the acknowledge is low and words remain drives the current `src_data` word on `host_dout`, sets `host_oe` to 1, pulses `src_ready` once and uses up one word.
- R5: `host_oe` is 1 only after an accepted read strobe fall. It returns to 0 once the read strobe rise, or an acknowledge release, has been seen.
- R6: A rising write strobe while the acknowledge is low and words remain pulses `snk_valid` once, with `snk_data` equal to the bus word present at that edge, and uses up one word.
- R7: A strobe edge seen while the acknowledge is high moves no word. The remaining count, the source position and the sink are unchanged.
- R8: The strobe that toggles sets the direction of each word, so read and write words can be mixed within one transfer.
- R9: While words remain, `wide_n` is 1 (deasserted) whatever `pio_wide` is.
- R10: When the count reaches zero, `xfer_req` is 0 once the acknowledge is low, `host_oe` is 0 after the last read strobe rise, and further strobes move no word.
- R11: A `start` pulse while words remain is ignored. A new count is loaded only when the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Arm a transfer (taken only when idle) |
| start_words | input | CNT_W | Word count for the armed transfer |
| rd_stb_n | input | 1 | Host read strobe, asynchronous, active low |
| wr_stb_n | input | 1 | Host write strobe, asynchronous, active low |
| host_ack_n | input | 1 | Host DMA acknowledge, asynchronous, active low |
| host_din | input | DATA_W | Host data bus as seen by the device |
| host_dout | output | DATA_W | Word the device drives onto the host bus |
| host_oe | output | 1 | Output enable for `host_dout` |
| xfer_req | output | 1 | DMA request to the host |
| pio_wide | input | 1 | Register-access request for the 16-bit indicator |
| wide_n | output | 1 | 16-bit access indicator, active low |
| src_valid | input | 1 | Local source has a word |
| src_data | input | DATA_W | Local source word |
| src_ready | output | 1 | One-cycle pop of the local source |
| snk_ready | input | 1 | Local sink can accept a word |
| snk_valid | output | 1 | One-cycle push into the local sink |
| snk_data | output | DATA_W | Word pushed into the local sink |

## Verification
Transfers of one to four words are run in three direction patterns: all reads, all writes, and reads alternating with writes. These separate source sequencing, sink capture and per-word direction choice. Strobes sent with the acknowledge released, and a second `start` sent mid-transfer, are each followed by real transfers. The data seen and the request's drop point show whether the stray event moved a word or reloaded the count. A readiness sweep drops the local side's readiness while the acknowledge is high and then while it is low. This separates the rule that holds the request until the acknowledge is seen from the rule that ends it.

// File: rtl/pata_dma_pkg.sv
package pata_dma_pkg;

  // Next value of the request flag given the present flag and conditions.
  function automatic logic req_step(input logic req, input logic active,
                                    input logic ready, input logic ack_low);
    if (!req) return active && ready && !ack_low;
    return !(ack_low && (!active || !ready));
  endfunction

  // Count after an optional word move; saturates at zero.
  function automatic int unsigned count_step(input int unsigned cnt, input logic moved);
    if (moved && cnt != 0) return cnt - 1;
    return cnt;
  endfunction

endpackage

// File: rtl/pata_dma_sync.sv
module pata_dma_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pata_dma_edge.sv
module pata_dma_edge #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise[i] = lvl[i] & ~prev[i];
    assign fall[i] = ~lvl[i] & prev[i];
  end
endmodule

// File: rtl/pata_dma_flow.sv
module pata_dma_flow
  import pata_dma_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_words,
  input  logic             word_moved,
  input  logic             ready,
  input  logic             ack_low,
  output logic [CNT_W-1:0] rem,
  output logic             active,
  output logic             req
);
  assign active = (rem != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0;
      req <= 1'b0;
    end else begin
      if (!active && start) rem <= start_words;
      else                  rem <= CNT_W'(count_step(int'(rem), word_moved));
      req <= req_step(req, active, ready, ack_low);
    end
  end
endmodule

// File: rtl/pata_dma_dev.sv
module pata_dma_dev #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_words,
  input  logic              rd_stb_n,
  input  logic              wr_stb_n,
  input  logic              host_ack_n,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_oe,
  output logic              xfer_req,
  input  logic              pio_wide,
  output logic              wide_n,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic              snk_ready,
  output logic              snk_valid,
  output logic [DATA_W-1:0] snk_data
);
  localparam int CTL_W = 3;  // {ack, write, read}

  logic [CTL_W-1:0]  ctl_sync, ctl_rise, ctl_fall;
  logic [DATA_W-1:0] din_sync;
  logic              rd_lvl, ack_lvl;
  logic              rd_fall, rd_rise, wr_rise;
  logic              ack_low, local_ready, dma_active;
  logic              rd_ok, wr_ok, word_moved;
  logic [CNT_W-1:0]  rem;

  pata_dma_sync #(.W(CTL_W), .RST_VAL('1)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({host_ack_n, wr_stb_n, rd_stb_n}), .q(ctl_sync));

  pata_dma_sync #(.W(DATA_W), .RST_VAL('0)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .d(host_din), .q(din_sync));

  pata_dma_edge #(.W(CTL_W), .RST_VAL('1)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(ctl_sync), .rise(ctl_rise), .fall(ctl_fall));

  assign rd_lvl  = ctl_sync[0];
  assign ack_lvl = ctl_sync[2];
  assign rd_fall = ctl_fall[0];
  assign rd_rise = ctl_rise[0];
  assign wr_rise = ctl_rise[1];
  assign ack_low = ~ack_lvl;

  assign local_ready = src_valid | snk_ready;

  // Word events: only with acknowledge held and words left; read wins a tie.
  assign rd_ok      = rd_fall & ack_low & dma_active;
  assign wr_ok      = wr_rise & ack_low & dma_active & ~rd_ok;
  assign word_moved = rd_ok | wr_ok;

  pata_dma_flow #(.CNT_W(CNT_W)) u_flow (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_words(start_words),
    .word_moved(word_moved), .ready(local_ready), .ack_low(ack_low),
    .rem(rem), .active(dma_active), .req(xfer_req));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_oe   <= 1'b0;
      host_dout <= '0;
    end else begin
      if (rd_ok) begin
        host_oe   <= 1'b1;
        host_dout <= src_data;
      end else if (rd_rise || rd_lvl || !ack_low) begin
        host_oe   <= 1'b0;
      end
    end
  end

  assign src_ready = rd_ok;
  assign snk_valid = wr_ok;
  assign snk_data  = din_sync;
  assign wide_n    = ~(pio_wide & ~dma_active);
endmodule

// File: rtl/pata_dma_dev_chk.sv
module pata_dma_dev_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_req,
  input logic             ack_low,
  input logic [CNT_W-1:0] rem,
  input logic             local_ready,
  input logic             rd_ok,
  input logic             wr_ok,
  input logic             rd_rise,
  input logic             host_oe,
  input logic             wide_n,
  input logic             dma_active
);
  p_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_req) |-> $past(rem != '0 && local_ready && !ack_low));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_req) |-> $past(ack_low));

  p_oe_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_oe) |-> $past(rd_ok));

  p_oe_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_oe && rd_rise) |=> !host_oe);

  p_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok || wr_ok) |=> (rem == $past(rem) - CNT_W'(1)));

  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_low && dma_active) |=> $stable(rem));

  p_wide_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_active |-> wide_n);

  p_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_active && ack_low) |=> !xfer_req);
endmodule

bind pata_dma_dev pata_dma_dev_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .ack_low(ack_low),
  .rem(rem), .local_ready(local_ready), .rd_ok(rd_ok), .wr_ok(wr_ok),
  .rd_rise(rd_rise), .host_oe(host_oe), .wide_n(wide_n),
  .dma_active(dma_active));

// File: tb/pata_dma_dev_test.sv
module pata_dma_dev_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] start_words = '0;
  logic rd_n = 1'b1, wr_n = 1'b1, ack_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic oe, req, pio_wide = 1'b1, wide_n;
  logic src_valid = 1'b1, snk_ready = 1'b1;
  logic [DW-1:0] src_data;
  logic src_ready, snk_valid;
  logic [DW-1:0] snk_data;

  int total = 0, bad = 0;
  int src_idx = 0, snk_cnt = 0;
  logic [DW-1:0] snk_last = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pata_dma_dev #(.DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_words(start_words),
    .rd_stb_n(rd_n), .wr_stb_n(wr_n), .host_ack_n(ack_n), .host_din(din),
    .host_dout(dout), .host_oe(oe), .xfer_req(req), .pio_wide(pio_wide),
    .wide_n(wide_n), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .snk_ready(snk_ready), .snk_valid(snk_valid),
    .snk_data(snk_data));

  function automatic logic [DW-1:0] pat(input int i);
    return 16'hC3A5 ^ DW'(i * 257);
  endfunction

  assign src_data = pat(src_idx);

  // Local buffer models.
  always @(posedge clk) begin
    if (src_ready) src_idx <= src_idx + 1;
    if (snk_valid) begin
      snk_cnt  <= snk_cnt + 1;
      snk_last <= snk_data;
    end
  end

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic arm(input int n);
    start = 1'b1; start_words = CW'(n);
    @(negedge clk);
    start = 1'b0;
    settle();
  endtask

  task automatic host_read(input int exp_idx);
    rd_n = 1'b0; settle();
    check(oe == 1'b1, "R4 oe", int'(oe), 1);
    check(dout == pat(exp_idx), "R4 data", int'(dout), int'(pat(exp_idx)));
    rd_n = 1'b1; settle();
    check(oe == 1'b0, "R5 release", int'(oe), 0);
  endtask

  task automatic host_write(input logic [DW-1:0] w, input int exp_cnt);
    din = w;
    wr_n = 1'b0; settle();
    wr_n = 1'b1; settle();
    check(snk_cnt == exp_cnt, "R6 count", snk_cnt, exp_cnt);
    check(snk_last == w, "R6 data", int'(snk_last), int'(w));
  endtask

  initial begin
    int guard = 0;
    while (!done && guard < 150000) begin
      @(posedge clk);
      guard++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", guard, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ridx = 0, wcnt = 0;
    repeat (5) @(negedge clk);
    check(req == 1'b0, "R1 req", int'(req), 0);
    check(oe == 1'b0, "R1 oe", int'(oe), 0);
    rst_n = 1'b1;
    settle();
    check(req == 1'b0, "R1 req idle", int'(req), 0);
    check(wide_n == 1'b0, "R1 wide", int'(wide_n), 0);

    // Sweep: modes read, write, alternating (R8) over lengths 1..4.
    for (int mode = 0; mode < 3; mode++) begin
      for (int n = 1; n <= 4; n++) begin
        arm(n);
        check(req == 1'b1, "R2 raise", int'(req), 1);
        check(wide_n == 1'b1, "R9 wide off", int'(wide_n), 1);
        settle();
        check(req == 1'b1, "R3 hold no ack", int'(req), 1);
        ack_n = 1'b0; settle();
        for (int w = 0; w < n; w++) begin
          bit is_rd = (mode == 0) || (mode == 2 && (w % 2 == 0));
          if (is_rd) begin
            host_read(ridx); ridx++;
          end else begin
            wcnt++;
            host_write(DW'(16'h5A00 + mode * 16 + n * 4 + w), wcnt);
          end
          check(src_idx == ridx, "R8 source position", src_idx, ridx);
          if (w < n - 1) check(req == 1'b1, "R3 mid", int'(req), 1);
        end
        check(req == 1'b0, "R10 req end", int'(req), 0);
        check(oe == 1'b0, "R10 bus end", int'(oe), 0);
        rd_n = 1'b0; settle(); rd_n = 1'b1; settle();
        check(src_idx == ridx, "R10 no move", src_idx, ridx);
        ack_n = 1'b1; settle();
        check(req == 1'b0, "R10 stays low", int'(req), 0);
        check(wide_n == 1'b0, "R9 idle wide", int'(wide_n), 0);
      end
    end

    // R7: strobes with acknowledge released move nothing.
    arm(2);
    rd_n = 1'b0; settle(); rd_n = 1'b1; settle();
    din = 16'h7777; wr_n = 1'b0; settle(); wr_n = 1'b1; settle();
    check(oe == 1'b0, "R7 no drive", int'(oe), 0);
    check(src_idx == ridx, "R7 source", src_idx, ridx);
    check(snk_cnt == wcnt, "R7 sink", snk_cnt, wcnt);
    ack_n = 1'b0; settle();
    host_read(ridx); ridx++;
    check(req == 1'b1, "R7 count kept", int'(req), 1);
    host_read(ridx); ridx++;
    check(req == 1'b0, "R7 end", int'(req), 0);
    ack_n = 1'b1; settle();

    // R11: start while busy is ignored.
    arm(2);
    arm(5);
    ack_n = 1'b0; settle();
    host_read(ridx); ridx++;
    host_read(ridx); ridx++;
    check(req == 1'b0, "R11 no reload", int'(req), 0);
    ack_n = 1'b1; settle();
    check(wide_n == 1'b0, "R11 idle", int'(wide_n), 0);

    // R2/R3: readiness sweep.
    src_valid = 1'b0; snk_ready = 1'b0;
    arm(1);
    check(req == 1'b0, "R2 not ready", int'(req), 0);
    src_valid = 1'b1; settle();
    check(req == 1'b1, "R2 ready", int'(req), 1);
    src_valid = 1'b0; settle();
    check(req == 1'b1, "R3 held until ack", int'(req), 1);
    ack_n = 1'b0; settle();
    check(req == 1'b0, "R3 drop on ack", int'(req), 0);
    snk_ready = 1'b1; settle();
    check(req == 1'b0, "R2 no raise under ack", int'(req), 0);
    ack_n = 1'b1; settle();
    check(req == 1'b1, "R2 re-raise", int'(req), 1);
    ack_n = 1'b0; settle();
    wcnt++;
    host_write(16'hBEEF, wcnt);
    check(req == 1'b0, "R10 last write", int'(req), 0);
    ack_n = 1'b1; src_valid = 1'b1; settle();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule